// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block sits in front of a synchronous burst memory and produces the word address for every access of a burst. When either of two active-low address strobes is seen on a rising clock edge, it registers the external address and starts a new burst. On later edges where the active-low advance input is asserted, it steps a small wrap counter. Only the low counter-width bits of the address change. The upper bits stay fixed until the next strobe.

A registered order-select input chooses how the counter maps onto the low address bits. Linear order adds the count to the starting low bits modulo the burst length. Interleaved order XORs the count with the starting low bits. With the default two-bit counter a burst covers four words and then wraps back to its first word. It never carries into the upper bits. The controller strobe cuts off any burst in progress. When both strobes are active on one edge, the processor strobe wins, and the load is the same as a controller-strobe load. A one-cycle flag marks the first address of each burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released with no strobe, `addr_out` is all zeros and `burst_start` is 0.
- R2: On a rising edge where `strobe_cpu_n` or `strobe_ctl_n` is 0, `addr_in` is registered. From that edge onward `addr_out` equals that address and `burst_start` is 1 for exactly that one cycle.
- R3: A controller-strobe load in the middle of a burst abandons the old burst. The next address is the newly registered one with count zero.
- R4: With both strobes at 0 on the same edge, the result equals a single-strobe load, and `adv_n` is ignored on that edge.
- R5: On an edge with no strobe and `adv_n` = 1, the count is held. With an unchanged order select, `addr_out` does not change.
- R6: Bits above the counter width of `addr_out` never change between loads, including across a wrap from all-ones low bits.
- R7: With `order_sel` = 0 (linear), after k advances the low bits equal (start + k) mod 2^CNT_W.
- R8: With `order_sel` = 1 (interleaved), after k advances the low bits equal start XOR k.
- R9: After 2^CNT_W advances the address returns to the burst's first address.
- R10: `order_sel` is registered on each edge. A change of order in the middle of a burst remaps the current count from the next edge onward, without restarting the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External word address |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, higher priority |
| strobe_ctl_n | input | 1 | Controller address strobe, active low, aborts a burst |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current word address |
| burst_start | output | 1 | High in the first cycle of a new burst |

## Verification
The bench builds the block with ADDR_W = 12 and CNT_W = 2. Four-word bursts then wrap within a few cycles, so every starting low value can be reached in both orders. A 12-bit address is short enough that a start of 0xFFF makes any carry into the upper bits show up directly. The stimulus covers loads from each strobe, a controller abort in the middle of a burst, a load with both strobes and the advance input active, hold cycles, and an order switch in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } burst_ctl_t;

    function automatic burst_ctl_t decode_ctl(input logic cpu_n,
                                              input logic ctl_n,
                                              input logic adv_n);
        burst_ctl_t c;
        c.load = !cpu_n || !ctl_n;
        c.step = !c.load && !adv_n;
        return c;
    endfunction

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
    import burst_pkg::*;
(
    input  logic       strobe_cpu_n,
    input  logic       strobe_ctl_n,
    input  logic       adv_n,
    output burst_ctl_t ctl
);

    always_comb begin
        ctl = decode_ctl(strobe_cpu_n, strobe_ctl_n, adv_n);
    end

endmodule

// File: rtl/burst_wrap_counter.sv
module burst_wrap_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_lo,
    input  logic [CNT_W-1:0] cnt,
    input  order_e           mode,
    output logic [CNT_W-1:0] lo
);

    always_comb begin
        unique case (mode)
            ORD_XOR:    lo = start_lo ^ cnt;
            default:    lo = start_lo + cnt;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_start
);

    localparam int HI_W = ADDR_W - CNT_W;

    burst_ctl_t        ctl;
    logic [ADDR_W-1:0] base_q;
    order_e            mode_q;
    logic              start_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lo;

    burst_load_ctrl u_ctl (
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .adv_n        (adv_n),
        .ctl          (ctl)
    );

    burst_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.load),
        .step  (ctl.step),
        .cnt   (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            mode_q  <= ORD_LINEAR;
            start_q <= 1'b0;
        end else begin
            if (ctl.load) begin
                base_q <= addr_in;
            end
            mode_q  <= order_e'(order_sel);
            start_q <= ctl.load;
        end
    end

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .start_lo (base_q[CNT_W-1:0]),
        .cnt      (cnt),
        .mode     (mode_q),
        .lo       (lo)
    );

    assign addr_out    = {base_q[ADDR_W-1 -: HI_W], lo};
    assign burst_start = start_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_cpu_n,
    input logic              strobe_ctl_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out,
    input logic              burst_start
);

    logic any_load;
    assign any_load = !strobe_cpu_n || !strobe_ctl_n;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && !burst_start));

    // R2, R4
    a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (rst)
        any_load |=> (addr_out == $past(addr_in) && burst_start));

    // R2
    a_r2_flag_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> !burst_start);

    // R5
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!any_load && adv_n && !$past(rst) && order_sel == $past(order_sel))
        |=> $stable(addr_out));

    // R6
    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

    // R7
    a_r7_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!any_load && !adv_n && !$past(rst) && !order_sel && !$past(order_sel))
        |=> (addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_in      (addr_in),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .order_sel    (order_sel),
    .addr_out     (addr_out),
    .burst_start  (burst_start)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int AW = 12;
    localparam int CW = 2;

    typedef struct {
        logic [AW-1:0] addr;
        logic          start;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_cpu_n = 1'b1;
    logic          strobe_ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;
    logic          burst_start;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  done = 0;
    exp_t q[$];

    logic [AW-1:0] m_base = '0;
    logic [CW-1:0] m_cnt = '0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .adv_n        (adv_n),
        .order_sel    (order_sel),
        .addr_out     (addr_out),
        .burst_start  (burst_start)
    );

    task automatic step(input logic [AW-1:0] a, input logic cpu_n,
                        input logic ctl_n, input logic adv, input logic mode,
                        input string tag);
        exp_t e;
        logic [CW-1:0] lo;
        @(negedge clk);
        addr_in = a; strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n;
        adv_n = adv; order_sel = mode;
        if (!cpu_n || !ctl_n) begin
            m_base = a; m_cnt = '0; e.start = 1'b1;
        end else begin
            e.start = 1'b0;
            if (!adv) m_cnt = m_cnt + CW'(1);
        end
        lo = mode ? (m_base[CW-1:0] ^ m_cnt) : (m_base[CW-1:0] + m_cnt);
        e.addr = {m_base[AW-1:CW], lo};
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (addr_out !== e.addr || burst_start !== e.start) begin
                    n_bad++;
                    $display("FAIL %s: addr got %h exp %h, start got %b exp %b",
                             e.tag, addr_out, e.addr, burst_start, e.start);
                end
            end
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (addr_out !== '0 || burst_start !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: addr got %h exp 000, start got %b exp 0", addr_out, burst_start);
        end
        rst = 1'b0;
        // R1: idle cycle after release
        step(12'h5A5, 1, 1, 1, 0, "R1");

        // R2, R7, R9: processor load, linear, full wrap
        step(12'h5A2, 0, 1, 1, 0, "R2");
        step(12'h000, 1, 1, 0, 0, "R7");
        step(12'h000, 1, 1, 1, 0, "R5");
        step(12'h000, 1, 1, 0, 0, "R7");
        step(12'h000, 1, 1, 0, 0, "R7");
        step(12'h000, 1, 1, 0, 0, "R9");

        // R6: all-ones upper bits, start low 11, linear wrap
        step(12'hFFF, 0, 1, 1, 0, "R2");
        for (int i = 0; i < 4; i++) step(12'h000, 1, 1, 0, 0, "R6");

        // R8: controller load, interleaved from each start value
        for (int s = 0; s < 4; s++) begin
            step(12'h3F0 | AW'(s), 1, 0, 1, 1, "R2");
            for (int k = 0; k < 4; k++) step(12'h000, 1, 1, 0, 1, "R8");
        end

        // R3: controller abort mid-burst
        step(12'h120, 0, 1, 1, 0, "R2");
        step(12'h000, 1, 1, 0, 0, "R7");
        step(12'h7B3, 1, 0, 0, 0, "R3");
        step(12'h000, 1, 1, 0, 0, "R3");

        // R4: both strobes with advance active
        step(12'hA52, 0, 0, 0, 1, "R4");
        step(12'h000, 1, 1, 1, 1, "R5");
        step(12'h000, 1, 1, 0, 1, "R8");

        // R10: order switch mid-burst
        step(12'h801, 0, 1, 1, 0, "R2");
        step(12'h000, 1, 1, 0, 0, "R7");
        step(12'h000, 1, 1, 0, 0, "R7");
        step(12'h000, 1, 1, 1, 1, "R10");
        step(12'h000, 1, 1, 0, 1, "R10");
        step(12'h000, 1, 1, 0, 0, "R10");
        step(12'h000, 1, 1, 1, 0, "R5");

        repeat (3) @(posedge clk);
        #6;
        done = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule